// File: doc/BRIEF.md
# Combined Flash and SRAM Device Access Decoder

This block is the SRAM-side control logic of a memory device that shares one set of pins between a flash array and a static RAM. It samples the external control pins on a fast internal clock. The pins are an active-low SRAM enable, an active-high SRAM enable, an active-low flash enable, write enable, output enable and two byte strobes. From them it decides which bank, if any, is addressed, and it runs read and write cycles against a small word array that stands in for the RAM.

Reads drive the 16-bit data bus one byte lane at a time. Each lane has its own output enable, and a lane whose enable is low counts as high impedance. A write is committed when the write condition ends, whichever control pin ends it. The word written is the address and data sampled just before that release. The flash itself is outside the block. It is represented only by a select output and a busy input, which is returned as a ready flag.

The RAM occupies the lowest `SRAM_WORDS` word addresses, where `SRAM_WORDS` is a power of two. Reads and writes each take the same fixed number of internal samples.

Top module: `combo_sram_ctrl`

## Requirements
- R1: `sram_sel` is 1 exactly when the pins sampled one clock earlier had `sram_en_n`=0, `sram_en_hi`=1 and `flash_en_n`=1.
- R2: Exactly one of `sram_sel`, `flash_sel`, `standby` and `conflict` is 1 at any time. `flash_sel` is 1 when `flash_en_n`=0 and the two SRAM enables are not both active. `standby` is 1 when nothing is selected, for example with `sram_en_n`=1, `sram_en_hi`=0 and `flash_en_n`=1.
- R3: The data lanes are driven only while the SRAM is selected, `oe_n`=0, `we_n`=1 and the address is inside the RAM. `dq_out` then carries the stored word on the enabled lanes and 0 on the others.
- R4: With `oe_n`=1, `dq_oe` is 00 (the whole bus is high impedance).
- R5: A write is active while the SRAM is selected, `we_n`=0 and the address is in range. When it ends, the address and data sampled on the last active sample are written. The write can end by `we_n` rising, by `sram_en_n` rising or by `sram_en_hi` falling. An address or data change made in the same clock as the release is not used.
- R6: When both SRAM enables are active and `flash_en_n`=0, `conflict` is 1, no lane is driven and nothing is written.
- R7: `ub_n` gates lane 1 (`dq_out[15:8]`, `dq_oe[1]`) and `lb_n` gates lane 0 (`dq_out[7:0]`, `dq_oe[0]`), strobes active low, for reads and writes alike. A lane whose strobe is high during a write keeps its stored byte.
- R8: A word address at or above `SRAM_WORDS` gives no read drive and no write, and the RAM word it would alias to is left unchanged.
- R9: After reset `standby`=1 and `dq_oe`=00. Every decoded output follows the pins with one clock of latency.
- R10: `flash_ready` is the inverse of `flash_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sram_en_n | input | 1 | Active-low SRAM enable pin |
| sram_en_hi | input | 1 | Active-high SRAM enable pin |
| flash_en_n | input | 1 | Active-low flash enable pin |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| ub_n | input | 1 | Active-low upper byte strobe |
| lb_n | input | 1 | Active-low lower byte strobe |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data from the bus |
| flash_busy | input | 1 | Busy indication from the flash array |
| sram_sel | output | 1 | SRAM bank selected |
| flash_sel | output | 1 | Flash bank selected |
| standby | output | 1 | No bank selected |
| conflict | output | 1 | SRAM and flash enabled together |
| flash_ready | output | 1 | Flash ready flag |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |

## Verification
The bench builds the block with `ADDR_W`=6 and `SRAM_WORDS`=32. With these values one address bit lies above the RAM, so out-of-range addresses can be tested, along with the in-range word that each of them aliases to. The small array also lets a reference copy follow every masked write. Writes are released in three ways: by write enable, by the active-high enable falling, and by an address and data change in the same clock as the release.

// File: rtl/combo_pkg.sv
package combo_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef struct packed {
        logic sram_en_n;
        logic sram_en_hi;
        logic flash_en_n;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sram_en_n: 1'b1, sram_en_hi: 1'b0,
                                    flash_en_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                    ub_n: 1'b1, lb_n: 1'b1};

    typedef enum logic [1:0] {
        BANK_NONE  = 2'd0,
        BANK_SRAM  = 2'd1,
        BANK_FLASH = 2'd2,
        BANK_CLASH = 2'd3
    } bank_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [LANES-1:0] lanes;
    } access_t;

    function automatic logic sram_enables_on(pins_t p);
        return !p.sram_en_n && p.sram_en_hi;
    endfunction

    function automatic bank_e decode_bank(pins_t p);
        if (sram_enables_on(p) && !p.flash_en_n) return BANK_CLASH;
        if (sram_enables_on(p))                  return BANK_SRAM;
        if (!p.flash_en_n)                       return BANK_FLASH;
        return BANK_NONE;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(pins_t p);
        return {!p.ub_n, !p.lb_n};
    endfunction

endpackage

// File: rtl/combo_pin_sampler.sv
module combo_pin_sampler
    import combo_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  pins_t               pins_in,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [DATA_W-1:0]   data_in,
    output pins_t               pins_q,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [DATA_W-1:0]   data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= PINS_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            pins_q <= pins_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/combo_bank_decode.sv
module combo_bank_decode
    import combo_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 8
) (
    input  pins_t             pins_q,
    input  logic [ADDR_W-1:0] addr_q,
    output bank_e             bank,
    output access_t           acc
);

    logic in_range;

    generate
        if (ADDR_W > IDX_W) begin : g_upper_bits
            assign in_range = (addr_q[ADDR_W-1:IDX_W] == '0);
        end else begin : g_full_map
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        bank      = decode_bank(pins_q);
        acc.rd    = (bank == BANK_SRAM) && in_range && !pins_q.oe_n && pins_q.we_n;
        acc.wr    = (bank == BANK_SRAM) && in_range && !pins_q.we_n;
        acc.lanes = lane_mask(pins_q);
    end

endmodule

// File: rtl/combo_write_tracker.sv
module combo_write_tracker
    import combo_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_now,
    input  logic [LANES-1:0]  lanes_now,
    input  logic [IDX_W-1:0]  idx_now,
    input  logic [DATA_W-1:0] data_now,
    output logic              commit,
    output logic [LANES-1:0]  commit_lanes,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data
);

    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q         <= 1'b0;
            commit_lanes <= '0;
            commit_idx   <= '0;
            commit_data  <= '0;
        end else begin
            wr_q <= wr_now;
            if (wr_now) begin
                commit_lanes <= lanes_now;
                commit_idx   <= idx_now;
                commit_data  <= data_now;
            end
        end
    end

    assign commit = wr_q && !wr_now;

endmodule

// File: rtl/combo_word_array.sv
module combo_word_array
    import combo_pkg::*;
#(
    parameter int WORDS = 256,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [7:0] lane_mem [WORDS];

            always_ff @(posedge clk) begin
                if (wr_en && wr_lanes[g]) begin
                    lane_mem[wr_idx] <= wr_data[g*8 +: 8];
                end
            end

            assign rd_data[g*8 +: 8] = lane_mem[rd_idx];
        end
    endgenerate

endmodule

// File: rtl/combo_sram_ctrl.sv
module combo_sram_ctrl
    import combo_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SRAM_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sram_en_n,
    input  logic              sram_en_hi,
    input  logic              flash_en_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    input  logic              flash_busy,
    output logic              sram_sel,
    output logic              flash_sel,
    output logic              standby,
    output logic              conflict,
    output logic              flash_ready,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe
);

    localparam int IDX_W = $clog2(SRAM_WORDS);

    pins_t               pins_in;
    pins_t               pins_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    bank_e               bank;
    access_t             acc;
    logic                commit;
    logic [LANES-1:0]    commit_lanes;
    logic [IDX_W-1:0]    commit_idx;
    logic [DATA_W-1:0]   commit_data;
    logic [DATA_W-1:0]   rd_data;
    logic [LANES-1:0]    lane_drive;

    always_comb begin
        pins_in.sram_en_n  = sram_en_n;
        pins_in.sram_en_hi = sram_en_hi;
        pins_in.flash_en_n = flash_en_n;
        pins_in.we_n       = we_n;
        pins_in.oe_n       = oe_n;
        pins_in.ub_n       = ub_n;
        pins_in.lb_n       = lb_n;
    end

    combo_pin_sampler #(.ADDR_W(ADDR_W)) i_sampler (
        .clk     (clk),
        .rst     (rst),
        .pins_in (pins_in),
        .addr_in (addr),
        .data_in (dq_in),
        .pins_q  (pins_q),
        .addr_q  (addr_q),
        .data_q  (data_q)
    );

    combo_bank_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_decode (
        .pins_q (pins_q),
        .addr_q (addr_q),
        .bank   (bank),
        .acc    (acc)
    );

    combo_write_tracker #(.IDX_W(IDX_W)) i_tracker (
        .clk          (clk),
        .rst          (rst),
        .wr_now       (acc.wr),
        .lanes_now    (acc.lanes),
        .idx_now      (addr_q[IDX_W-1:0]),
        .data_now     (data_q),
        .commit       (commit),
        .commit_lanes (commit_lanes),
        .commit_idx   (commit_idx),
        .commit_data  (commit_data)
    );

    combo_word_array #(.WORDS(SRAM_WORDS), .IDX_W(IDX_W)) i_array (
        .clk      (clk),
        .wr_en    (commit),
        .wr_lanes (commit_lanes),
        .wr_idx   (commit_idx),
        .wr_data  (commit_data),
        .rd_idx   (addr_q[IDX_W-1:0]),
        .rd_data  (rd_data)
    );

    assign lane_drive = acc.rd ? acc.lanes : '0;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_out_lane
            assign dq_out[g*8 +: 8] = lane_drive[g] ? rd_data[g*8 +: 8] : 8'h00;
        end
    endgenerate

    assign dq_oe       = lane_drive;
    assign sram_sel    = (bank == BANK_SRAM);
    assign flash_sel   = (bank == BANK_FLASH);
    assign standby     = (bank == BANK_NONE);
    assign conflict    = (bank == BANK_CLASH);
    assign flash_ready = !flash_busy;

endmodule

// File: rtl/combo_sram_chk.sv
module combo_sram_chk #(
    parameter int ADDR_W     = 10,
    parameter int SRAM_WORDS = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              sram_en_n,
    input logic              sram_en_hi,
    input logic              flash_en_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              ub_n,
    input logic              lb_n,
    input logic [ADDR_W-1:0] addr,
    input logic              sram_sel,
    input logic              flash_sel,
    input logic              standby,
    input logic              conflict,
    input logic [1:0]        dq_oe
);

    AST_SEL_FROM_PINS: assert property (@(posedge clk) disable iff (rst)
        sram_sel |-> ($past(!sram_en_n) && $past(sram_en_hi) && $past(flash_en_n))); // R1

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        $countones({sram_sel, flash_sel, standby, conflict}) == 1); // R2

    AST_READ_NEEDS_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (dq_oe != 2'b00) |-> ($past(we_n) && sram_sel)); // R3

    AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n) |-> (dq_oe == 2'b00)); // R4

    AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (rst)
        conflict |-> (dq_oe == 2'b00)); // R6

    AST_UPPER_LANE: assert property (@(posedge clk) disable iff (rst)
        dq_oe[1] |-> !$past(ub_n)); // R7

    AST_LOWER_LANE: assert property (@(posedge clk) disable iff (rst)
        dq_oe[0] |-> !$past(lb_n)); // R7

    AST_IN_RANGE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (dq_oe != 2'b00) |-> ($past(addr) < ADDR_W'(SRAM_WORDS))); // R8

endmodule

bind combo_sram_ctrl combo_sram_chk #(.ADDR_W(ADDR_W), .SRAM_WORDS(SRAM_WORDS)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .sram_en_n  (sram_en_n),
    .sram_en_hi (sram_en_hi),
    .flash_en_n (flash_en_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .ub_n       (ub_n),
    .lb_n       (lb_n),
    .addr       (addr),
    .sram_sel   (sram_sel),
    .flash_sel  (flash_sel),
    .standby    (standby),
    .conflict   (conflict),
    .dq_oe      (dq_oe)
);

// File: tb/test_combo_sram_ctrl.sv
module test_combo_sram_ctrl;

    localparam int ADDR_W = 6;
    localparam int WORDS  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sram_en_n = 1'b1, sram_en_hi = 1'b0, flash_en_n = 1'b1;
    logic              we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       dq_in = '0;
    logic              flash_busy = 1'b0;
    logic              sram_sel, flash_sel, standby, conflict, flash_ready;
    logic [15:0]       dq_out;
    logic [1:0]        dq_oe;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] ref_mem [WORDS];

    always #5 clk = ~clk;

    combo_sram_ctrl #(.ADDR_W(ADDR_W), .SRAM_WORDS(WORDS)) i_combo_sram_ctrl (
        .clk(clk), .rst(rst), .sram_en_n(sram_en_n), .sram_en_hi(sram_en_hi),
        .flash_en_n(flash_en_n), .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n),
        .addr(addr), .dq_in(dq_in), .flash_busy(flash_busy),
        .sram_sel(sram_sel), .flash_sel(flash_sel), .standby(standby),
        .conflict(conflict), .flash_ready(flash_ready), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // pins {sram_en_n, sram_en_hi, flash_en_n, we_n, oe_n, ub_n, lb_n}
    // expect {sram_sel, flash_sel, standby, conflict, dq_oe[1], dq_oe[0]}
    localparam logic [12:0] VEC [12] = '{
        {7'b1011100, 6'b001000},
        {7'b0111000, 6'b100011},
        {7'b0111010, 6'b100001},
        {7'b0111001, 6'b100010},
        {7'b0111100, 6'b100000},
        {7'b0110011, 6'b100000},
        {7'b0011000, 6'b001000},
        {7'b1111000, 6'b001000},
        {7'b1001000, 6'b010000},
        {7'b0101000, 6'b000100},
        {7'b1101100, 6'b010000},
        {7'b0001000, 6'b010000}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] p, input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        {sram_en_n, sram_en_hi, flash_en_n, we_n, oe_n, ub_n, lb_n} = p;
        addr  = a;
        dq_in = d;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        drive(7'b1011111, '0, '0);
        tick();
    endtask

    task automatic write_word(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                              input logic ub, input logic lb);
        drive({5'b01101, ub, lb}, a, d);
        tick();
        tick();
        drive(7'b0111111, a, d);
        tick();
        tick();
        if (a < WORDS) begin
            if (!ub) ref_mem[a][15:8] = d[15:8];
            if (!lb) ref_mem[a][7:0]  = d[7:0];
        end
        go_idle();
    endtask

    task automatic read_word(input string tag, input logic [ADDR_W-1:0] a);
        drive(7'b0111000, a, '0);
        tick();
        check({tag, " lanes"}, {14'd0, dq_oe}, 16'h0003);
        check({tag, " data"}, dq_out, ref_mem[a]);
        go_idle();
    endtask

    initial begin
        #1_500_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R9 reset state
        check("R9 reset standby", {15'd0, standby}, 16'h0001);
        check("R9 reset dq_oe", {14'd0, dq_oe}, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        tick();

        foreach (VEC[i]) begin
            drive(VEC[i][12:6], 6'd1, '0);
            tick();
            check("R1 sram_sel", {15'd0, sram_sel}, {15'd0, VEC[i][5]});
            check("R2 flash_sel", {15'd0, flash_sel}, {15'd0, VEC[i][4]});
            check("R2 standby", {15'd0, standby}, {15'd0, VEC[i][3]});
            check("R6 conflict", {15'd0, conflict}, {15'd0, VEC[i][2]});
            check("R3 R4 R7 dq_oe", {14'd0, dq_oe}, {14'd0, VEC[i][1:0]});
        end
        go_idle();

        // R9 one clock latency: read pins applied, not yet sampled
        drive(7'b0111000, 6'd1, '0);
        #1;
        check("R9 latency before edge", {14'd0, dq_oe}, 16'h0000);
        go_idle();

        // R5 full word write then read
        write_word(6'd3, 16'hA55A, 1'b0, 1'b0);
        read_word("R5 word write", 6'd3);

        // R7 upper lane only write keeps lower byte
        write_word(6'd3, 16'h12FF, 1'b0, 1'b1);
        read_word("R7 upper masked write", 6'd3);
        check("R7 merged value", ref_mem[3], 16'h125A);

        // R7 lower lane only read
        drive(7'b0111010, 6'd3, '0);
        tick();
        check("R7 lower only lanes", {14'd0, dq_oe}, 16'h0001);
        check("R7 lower only data", dq_out, 16'h005A);
        go_idle();

        // R5 address and data change in the release clock are ignored
        write_word(6'd5, 16'h0F0F, 1'b0, 1'b0);
        drive(7'b0110100, 6'd4, 16'h1111);
        tick();
        tick();
        drive(7'b0111100, 6'd5, 16'h2222);
        tick();
        tick();
        ref_mem[4] = 16'h1111;
        go_idle();
        read_word("R5 release old addr", 6'd4);
        read_word("R5 release new addr untouched", 6'd5);

        // R5 release by active-high enable falling
        drive(7'b0110100, 6'd6, 16'h3C3C);
        tick();
        tick();
        drive(7'b0010100, 6'd6, 16'h3C3C);
        tick();
        tick();
        ref_mem[6] = 16'h3C3C;
        go_idle();
        read_word("R5 release by enable", 6'd6);

        // R6 conflicting enables never write
        write_word(6'd7, 16'h7777, 1'b0, 1'b0);
        drive(7'b0100100, 6'd7, 16'hDEAD);
        tick();
        check("R6 conflict flag", {15'd0, conflict}, 16'h0001);
        tick();
        drive(7'b0101100, 6'd7, 16'hDEAD);
        tick();
        tick();
        go_idle();
        read_word("R6 no write on conflict", 6'd7);

        // R8 out-of-range address: no write to alias, no drive
        write_word(6'd8, 16'h0808, 1'b0, 1'b0);
        write_word(6'd40, 16'hBEEF, 1'b0, 1'b0);
        drive(7'b0111000, 6'd40, '0);
        tick();
        check("R8 no drive out of range", {14'd0, dq_oe}, 16'h0000);
        check("R8 still selected", {15'd0, sram_sel}, 16'h0001);
        go_idle();
        read_word("R8 alias word untouched", 6'd8);

        // R10 busy passes through
        flash_busy = 1'b1;
        #1;
        check("R10 busy", {15'd0, flash_ready}, 16'h0000);
        flash_busy = 1'b0;
        #1;
        check("R10 ready", {15'd0, flash_ready}, 16'h0001);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule